// File: doc/BRIEF.md
# Multiplexed Eight-Digit Meter Display Driver

This block drives a row of eight common-cathode seven-segment digits, lighting one at a time in quick rotation so that a single set of segment lines serves the whole row. The row is split into two fixed-point fields: a distance reading with two whole and two fractional digits (shown as `00.00`), followed by a fare reading with three whole digits and one fractional digit (shown as `000.0`). Each field arrives as four BCD nibbles from upstream conversion logic.

A scan-rate enable, generated elsewhere, steps a digit address once per pulse. For the current address the block picks one BCD nibble, decodes it to segment drive, places the decimal point where that field's format requires it, and pulls low the one matching digit-select line. Segment data, decimal point and digit select are all derived from the same address register, so they move together.

Top module: `meter_disp_drv`

## Requirements
- R1: A synchronous active-high reset returns the digit address to 0, so that after the reset edge `dig_n` is `8'b1111_1110`.
- R2: Each clock edge with `scan_en` high advances the address by one; with `scan_en` low the address, and so every output for unchanged BCD inputs, holds.
- R3: The address wraps from 7 back to 0 on a `scan_en` pulse.
- R4: `dig_n` is one-hot active low: exactly one bit is low, bit k for address k, and it changes in the same cycle as `seg` and `dp`.
- R5: Addresses 0 to 3 show distance nibbles `dist_bcd[15:12]`, `[11:8]`, `[7:4]`, `[3:0]` in that order (most significant first); addresses 4 to 7 show `fare_bcd[15:12]` down to `fare_bcd[3:0]` the same way.
- R6: BCD values 0 to 9 give the usual seven-segment patterns with `seg[6]`=a, `seg[5]`=b, `seg[4]`=c, `seg[3]`=d, `seg[2]`=e, `seg[1]`=f, `seg[0]`=g, a lit segment driven high (0 is `7E`, 1 is `30`, 8 is `7F`, 9 is `7B`).
- R7: Nibble values 10 to 15 blank the digit: `seg` is all zero.
- R8: `dp` is high only at address 1 (distance whole-kilometre digit) and address 6 (fare whole-unit digit), regardless of the nibble shown.
- R9: When reset and `scan_en` are both high in one cycle, reset wins and the address becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Scan-rate enable; one pulse advances the digit address |
| dist_bcd | input | 16 | Distance as four BCD nibbles, most significant in [15:12] |
| fare_bcd | input | 16 | Fare as four BCD nibbles, most significant in [15:12] |
| seg | output | 7 | Segment drive a..g, active high |
| dp | output | 1 | Decimal point, active high |
| dig_n | output | 8 | Digit select, one-hot active low |

## Verification
Reset and an address step can fall in the same cycle; the bench walks the address to a middle digit, then raises `rst` and `scan_en` together and requires digit 0 afterwards, then holds the address with `scan_en` low to show the reset value is kept. A nibble change and an address step can also coincide: the bench sweeps every value 0 to 15 through every digit position and checks segments, decimal point and digit select together at each address, computing the expected segments from per-segment rules rather than a copied table.

// File: rtl/meter_disp_pkg.sv
package meter_disp_pkg;

    localparam int FIELD_DIGITS = 4;
    localparam int NUM_FIELDS   = 2;
    localparam int NUM_DIGITS   = FIELD_DIGITS * NUM_FIELDS;
    localparam int ADDR_W       = $clog2(NUM_DIGITS);
    localparam int NIB_W        = 4;
    localparam int FIELD_W      = FIELD_DIGITS * NIB_W;
    localparam int SEG_W        = 7;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [SEG_W-1:0]  segs_t;

    typedef enum logic {
        FIELD_DIST = 1'b0,
        FIELD_FARE = 1'b1
    } field_e;

    // one selected digit on its way to the decoder
    typedef struct packed {
        nib_t bcd;
        logic dp;
    } digit_pick_t;

    // decoded drive for the shared segment lines
    typedef struct packed {
        segs_t seg;
        logic  dp;
    } seg_drive_t;

    // bit 6 = a ... bit 0 = g; values above 9 blank
    function automatic segs_t bcd_to_segs(input nib_t v);
        segs_t s;
        case (v)
            4'd0:    s = 7'b111_1110;
            4'd1:    s = 7'b011_0000;
            4'd2:    s = 7'b110_1101;
            4'd3:    s = 7'b111_1001;
            4'd4:    s = 7'b011_0011;
            4'd5:    s = 7'b101_1011;
            4'd6:    s = 7'b101_1111;
            4'd7:    s = 7'b111_0000;
            4'd8:    s = 7'b111_1111;
            4'd9:    s = 7'b111_1011;
            default: s = '0;
        endcase
        return s;
    endfunction

    // position (0 = leftmost) of the digit carrying the decimal point
    function automatic int dp_slot(input int frac_digits);
        return FIELD_DIGITS - 1 - frac_digits;
    endfunction

endpackage

// File: rtl/meter_scan_addr.sv
module meter_scan_addr
    import meter_disp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  scan_en,
    output addr_t addr
);
    localparam addr_t LAST = addr_t'(NUM_DIGITS - 1);

    addr_t addr_q;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (scan_en)
            addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
    end

    assign addr = addr_q;

    // R1 R9
    reset_zero_chk: assert property (@(posedge clk) rst |=> (addr_q == '0));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_en && addr_q != LAST) |=> (addr_q == $past(addr_q) + 1'b1));

    // R2
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(addr_q));

    // R3
    wrap_last_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_en && addr_q == LAST) |=> (addr_q == '0));

endmodule

// File: rtl/meter_digit_pick.sv
module meter_digit_pick
    import meter_disp_pkg::*;
#(
    parameter int DIST_FRAC = 2,
    parameter int FARE_FRAC = 1
) (
    input  addr_t                  addr,
    input  logic [FIELD_W-1:0]     dist_bcd,
    input  logic [FIELD_W-1:0]     fare_bcd,
    output digit_pick_t            pick,
    output logic [NUM_DIGITS-1:0]  dig_n
);
    nib_t                  slot_bcd [NUM_DIGITS];
    logic [NUM_DIGITS-1:0] slot_dp;

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_slot
        localparam field_e FLD  = (k / FIELD_DIGITS == 0) ? FIELD_DIST : FIELD_FARE;
        localparam int     POS  = k % FIELD_DIGITS;
        localparam int     NIB  = FIELD_DIGITS - 1 - POS;
        localparam int     DPAT = dp_slot((FLD == FIELD_DIST) ? DIST_FRAC : FARE_FRAC);

        if (FLD == FIELD_DIST) begin : g_dist
            assign slot_bcd[k] = dist_bcd[NIB*NIB_W +: NIB_W];
        end else begin : g_fare
            assign slot_bcd[k] = fare_bcd[NIB*NIB_W +: NIB_W];
        end

        assign slot_dp[k] = (POS == DPAT);
        assign dig_n[k]   = (addr != addr_t'(k));
    end

    always_comb begin
        pick.bcd = slot_bcd[addr];
        pick.dp  = slot_dp[addr];
    end

endmodule

// File: rtl/meter_seg_decode.sv
module meter_seg_decode
    import meter_disp_pkg::*;
(
    input  digit_pick_t pick,
    output seg_drive_t  drive
);
    always_comb begin
        drive.seg = bcd_to_segs(pick.bcd);
        drive.dp  = pick.dp;
    end
endmodule

// File: rtl/meter_disp_drv.sv
module meter_disp_drv
    import meter_disp_pkg::*;
#(
    parameter int DIST_FRAC = 2,
    parameter int FARE_FRAC = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scan_en,
    input  logic [FIELD_W-1:0]    dist_bcd,
    input  logic [FIELD_W-1:0]    fare_bcd,
    output logic [SEG_W-1:0]      seg,
    output logic                  dp,
    output logic [NUM_DIGITS-1:0] dig_n
);
    localparam addr_t DIST_DP_ADDR = addr_t'(dp_slot(DIST_FRAC));
    localparam addr_t FARE_DP_ADDR = addr_t'(FIELD_DIGITS + dp_slot(FARE_FRAC));

    addr_t       addr;
    digit_pick_t pick;
    seg_drive_t  drive;

    meter_scan_addr u_scan (
        .clk     (clk),
        .rst     (rst),
        .scan_en (scan_en),
        .addr    (addr)
    );

    meter_digit_pick #(
        .DIST_FRAC (DIST_FRAC),
        .FARE_FRAC (FARE_FRAC)
    ) u_pick (
        .addr     (addr),
        .dist_bcd (dist_bcd),
        .fare_bcd (fare_bcd),
        .pick     (pick),
        .dig_n    (dig_n)
    );

    meter_seg_decode u_dec (
        .pick  (pick),
        .drive (drive)
    );

    assign seg = drive.seg;
    assign dp  = drive.dp;

    // R4
    one_low_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~dig_n) == 1);

    // R4
    sel_matches_addr_chk: assert property (@(posedge clk) disable iff (rst)
        dig_n[addr] == 1'b0);

    // R7
    blank_code_chk: assert property (@(posedge clk) disable iff (rst)
        (pick.bcd > 4'd9) |-> (seg == '0));

    // R8
    dp_place_chk: assert property (@(posedge clk) disable iff (rst)
        dp |-> (addr == DIST_DP_ADDR || addr == FARE_DP_ADDR));

endmodule

// File: tb/sim_meter_disp_drv.sv
module sim_meter_disp_drv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_en = 1'b0;
    logic [15:0] dist_bcd = '0;
    logic [15:0] fare_bcd = '0;
    logic [6:0]  seg;
    logic        dp;
    logic [7:0]  dig_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    meter_disp_drv u0 (
        .clk      (clk),
        .rst      (rst),
        .scan_en  (scan_en),
        .dist_bcd (dist_bcd),
        .fare_bcd (fare_bcd),
        .seg      (seg),
        .dp       (dp),
        .dig_n    (dig_n)
    );

    // per-segment lighting rules, a at bit 6
    function automatic logic [6:0] want_seg(input int v);
        logic a, b, c, d, e, f, g;
        if (v > 9) return 7'b0;
        a = !(v == 1 || v == 4);
        b = !(v == 5 || v == 6);
        c = (v != 2);
        d = !(v == 1 || v == 4 || v == 7);
        e = (v == 0 || v == 2 || v == 6 || v == 8);
        f = !(v == 1 || v == 2 || v == 3 || v == 7);
        g = !(v == 0 || v == 1 || v == 7);
        return {a, b, c, d, e, f, g};
    endfunction

    function automatic logic [7:0] want_sel(input int k);
        return ~(8'b1 << k);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_scan();
        @(negedge clk) scan_en = 1'b1;
        @(negedge clk) scan_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 dig_n after reset", dig_n, 8'hFE);

        // sweep every nibble value through every address
        for (int k = 0; k < 8; k++) begin
            for (int v = 0; v < 16; v++) begin
                int nib;
                logic [15:0] filler;
                nib = 3 - (k % 4);
                filler = 16'h0;
                for (int j = 0; j < 4; j++) filler[j*4 +: 4] = 4'((j + v + 3) % 10);
                filler[nib*4 +: 4] = 4'(v);
                if (k < 4) begin
                    dist_bcd = filler;
                    fare_bcd = 16'h8888;
                end else begin
                    fare_bcd = filler;
                    dist_bcd = 16'h8888;
                end
                #1;
                if (v > 9) chk("R7 blank code", seg, 7'b0);
                else if (k < 4) chk("R5 R6 distance digit", seg, want_seg(v));
                else chk("R5 R6 fare digit", seg, want_seg(v));
                chk("R8 decimal point", dp, (k == 1 || k == 6));
                chk("R4 digit select", dig_n, want_sel(k));
                @(negedge clk);
            end
            pulse_scan();
            #1;
            if (k == 7) chk("R3 wrap to 0", dig_n, 8'hFE);
            else chk("R2 step by one", dig_n, want_sel(k + 1));
        end

        // hold with enable low
        pulse_scan();
        pulse_scan();
        dist_bcd = 16'h1234;
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            #1;
            chk("R2 hold address", dig_n, want_sel(2));
            chk("R2 hold segments", seg, want_seg(3));
        end

        // reset and scan enable in one cycle
        pulse_scan();
        @(negedge clk);
        rst = 1'b1;
        scan_en = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        scan_en = 1'b0;
        #1;
        chk("R9 reset beats scan", dig_n, 8'hFE);
        chk("R1 reset segments", seg, want_seg(1));
        chk("R8 dp off at address 0", dp, 1'b0);
        @(negedge clk);
        #1;
        chk("R9 address stays after reset", dig_n, 8'hFE);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule